// File: doc/BRIEF.md
# Compare Timer with IR Capture

This block is a 16-bit timer/counter that can take on one of three jobs, chosen by a control register. In compare mode, a counter advances on a selected tick. Whenever the count equals a 16-bit data register, the counter returns to zero and a pin-level output toggles. The output is a square wave whose frequency is the tick rate divided by twice (data + 1).

In IR envelope mode, the same counter times the gap between the start of a window and the first rising edge of an infrared input. A pulse from an external window timer captures the count, clears the counter and arms the edge capture. The first IR rising edge after that captures the count again and disarms the capture. In carrier count mode, the counter advances on every rising edge of a carrier input, and the window pulse captures the total and restarts the count.

Software reaches the block through an 8-bit write port with four addresses. The block presents the capture value, an interrupt-pending flag and the toggle output with its pin enable. The carrier input and the IR input are both asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector before it is used.

Top module: `cmp_ir_timer`

## Requirements
- R1: In compare mode (control bit 5 = 0), on a tick where the count equals the data register, `pin_out` inverts and the count returns to 0. On any other tick, the count increments by one.
- R2: After reset, `pin_out`, `pin_oe`, `irq_flag`, `cap_val`, the counter and the control register are all 0, and the data register is 0xFFFF.
- R3: `irq_flag` sets on a compare match or on any capture when control bit 4 is 1. A write to address 3 clears it. If a set and a clear fall in the same cycle, the set wins.
- R4: With a steady tick and data register D, `pin_out` changes once every D+1 ticks.
- R5: `pin_oe` equals control bit 3, and changes only on the clock after a write to address 0.
- R6: Control bits 2:0 select the tick. Value 0 selects the synchronized carrier rising edge, and value k (1 to 7) selects `div_tick[k-1]`.
- R7: A write to address 1 stages the high byte of the data register. A write to address 2 loads the low byte and the staged high byte together. The compare value does not change until the low byte is written.
- R8: In envelope mode (bit 5 = 1, bit 6 = 0), `wt_ovf` copies the count into `cap_val`, clears the count and arms the edge capture. While armed, the first synchronized IR rising edge copies the count and disarms the capture, and later edges are ignored. The count runs on the selected tick. When `wt_ovf` and an IR edge fall in the same cycle, the overflow is handled and the edge is dropped.
- R9: In carrier count mode (bits 5 and 6 = 1), the count advances on each carrier rising edge whatever bits 2:0 hold. IR edges are ignored, and `wt_ovf` copies the count into `cap_val` and clears it.
- R10: A rising edge on `ir_in` or `carrier_in` first sampled at clock edge n acts at clock edge n+2.
- R11: While bit 5 is 1, `pin_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 control, 1 data high, 2 data low, 3 flag clear |
| wr_data | input | 8 | Write data |
| div_tick | input | 7 | One-cycle enables from the divided system-clock rates |
| carrier_in | input | 1 | Asynchronous carrier input |
| ir_in | input | 1 | Asynchronous IR input |
| wt_ovf | input | 1 | Window timer overflow strobe |
| cap_val | output | 16 | Captured count |
| irq_flag | output | 1 | Interrupt pending flag |
| pin_out | output | 1 | Toggle output |
| pin_oe | output | 1 | Pin override enable |

## Verification
In envelope mode, a window overflow and an armed IR edge can land on the same clock. In that case the overflow alone must be taken, and the edge must be lost. The bench raises `ir_in` exactly two clocks before it pulses `wt_ovf`, so that the synchronized edge meets the strobe. A behavioural model compares `cap_val` and `irq_flag` against the design on every clock. The bench also provokes a flag-clear write on the same clock as a compare match, and judges that the flag stays set.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DHI  = 2'd1,
        ADDR_DLO  = 2'd2,
        ADDR_ACK  = 2'd3
    } addr_e;

    typedef struct packed {
        logic             spare;
        logic             cnt_mode;
        logic             cap_en;
        logic             irq_en;
        logic             port_en;
        logic [SEL_W-1:0] clk_sel;
    } ctrl_t;
endpackage

// File: rtl/cit_edge_sync.sv
module cit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // last synchronized level high, previous level low
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cit_tick_sel.sv
module cit_tick_sel #(
    parameter int NUM_DIV = 7,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_DIV-1:0] div_tick,
    input  logic               car_edge,
    input  logic               car_only,
    output logic               tick
);
    always_comb begin
        tick = 1'b0;
        if (car_only || sel == '0) begin
            tick = car_edge;
        end else begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (int'(sel) == i + 1) tick = div_tick[i];
            end
        end
    end
endmodule

// File: rtl/cmp_ir_timer.sv
module cmp_ir_timer #(
    parameter int BYTE_W  = 8,
    parameter int NUM_DIV = 7,
    parameter int STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [NUM_DIV-1:0]  div_tick,
    input  logic                carrier_in,
    input  logic                ir_in,
    input  logic                wt_ovf,
    output logic [2*BYTE_W-1:0] cap_val,
    output logic                irq_flag,
    output logic                pin_out,
    output logic                pin_oe
);
    import cit_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;
    localparam int N_IN  = 2;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  dr;
        logic [CNT_W-1:0]  cap;
        logic [BYTE_W-1:0] stage;
        ctrl_t             ctrl;
        logic              tog;
        logic              irq;
        logic              armed;
    } state_t;

    state_t s_d, s_q;

    // input synchronizers: index 0 carrier, index 1 IR
    logic [N_IN-1:0] raw_in, rise_in;
    assign raw_in = {ir_in, carrier_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        cit_edge_sync #(.STAGES(STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise_in[g])
        );
    end

    logic car_edge, ir_edge, cap_mode, cnt_mode, tick, irq_en;
    logic [CNT_W-1:0] cnt_q, dr_q;
    assign car_edge = rise_in[0];
    assign ir_edge  = rise_in[1];
    assign cap_mode = s_q.ctrl.cap_en;
    assign cnt_mode = s_q.ctrl.cap_en & s_q.ctrl.cnt_mode;
    assign irq_en   = s_q.ctrl.irq_en;
    assign cnt_q    = s_q.cnt;
    assign dr_q     = s_q.dr;

    cit_tick_sel #(.NUM_DIV(NUM_DIV), .SEL_W(SEL_W)) tick_i (
        .sel     (s_q.ctrl.clk_sel),
        .div_tick(div_tick),
        .car_edge(car_edge),
        .car_only(cnt_mode),
        .tick    (tick)
    );

    addr_e addr;
    assign addr = addr_e'(wr_sel);

    always_comb begin
        logic set_irq;
        s_d     = s_q;
        set_irq = 1'b0;

        if (!cap_mode) begin
            if (tick) begin
                if (s_q.cnt == s_q.dr) begin
                    s_d.cnt = '0;
                    s_d.tog = ~s_q.tog;
                    set_irq = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end
        end else if (!cnt_mode) begin
            if (wt_ovf) begin
                s_d.cap   = s_q.cnt;
                s_d.cnt   = '0;
                s_d.armed = 1'b1;
                set_irq   = 1'b1;
            end else begin
                if (ir_edge && s_q.armed) begin
                    s_d.cap   = s_q.cnt;
                    s_d.armed = 1'b0;
                    set_irq   = 1'b1;
                end
                if (tick) s_d.cnt = s_q.cnt + ONE;
            end
        end else begin
            if (wt_ovf) begin
                s_d.cap = s_q.cnt;
                s_d.cnt = '0;
                set_irq = 1'b1;
            end else if (tick) begin
                s_d.cnt = s_q.cnt + ONE;
            end
        end

        if (set_irq && s_q.ctrl.irq_en) s_d.irq = 1'b1;
        else if (wr_en && addr == ADDR_ACK) s_d.irq = 1'b0;

        if (wr_en) begin
            case (addr)
                ADDR_CTRL: s_d.ctrl  = ctrl_t'(wr_data[7:0]);
                ADDR_DHI:  s_d.stage = wr_data;
                ADDR_DLO:  s_d.dr    = {s_q.stage, wr_data};
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dr  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_val  = s_q.cap;
    assign irq_flag = s_q.irq;
    assign pin_out  = s_q.tog;
    assign pin_oe   = s_q.ctrl.port_en;
endmodule

// File: rtl/cit_chk.sv
module cit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             wt_ovf,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             irq_flag,
    input logic [CNT_W-1:0] cap_val,
    input logic             tick,
    input logic             ir_edge,
    input logic             cap_mode,
    input logic             irq_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] dr_q
);
    AST_TOGGLE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(tick && !cap_mode && cnt_q == dr_q)); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !cap_mode && cnt_q == dr_q) |-> cnt_q == '0); // R4

    AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && wr_sel == 2'd0) |-> $stable(pin_oe)); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(irq_en)); // R3

    AST_CAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> $past(cap_mode && (wt_ovf || ir_edge))); // R8

    AST_HOLD_IN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_mode) |-> $stable(pin_out)); // R11
endmodule

bind cmp_ir_timer cit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wt_ovf  (wt_ovf),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq_flag(irq_flag),
    .cap_val (cap_val),
    .tick    (tick),
    .ir_edge (ir_edge),
    .cap_mode(cap_mode),
    .irq_en  (irq_en),
    .cnt_q   (cnt_q),
    .dr_q    (dr_q)
);

// File: tb/cmp_ir_timer_tb_top.sv
module cmp_ir_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [6:0]  div_tick = 7'd0;
    logic        carrier_in = 1'b0;
    logic        ir_in = 1'b0;
    logic        wt_ovf = 1'b0;
    logic [15:0] cap_val;
    logic        irq_flag, pin_out, pin_oe;

    always #5 clk = ~clk;

    cmp_ir_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .div_tick(div_tick), .carrier_in(carrier_in),
        .ir_in(ir_in), .wt_ovf(wt_ovf), .cap_val(cap_val),
        .irq_flag(irq_flag), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string phase = "R2";
    int    tick_pct = 50;
    bit    car_rand = 0;
    int    toggles = 0;

    // behavioural reference model
    logic [15:0] m_cnt, m_dr, m_cap;
    logic [7:0]  m_stage, m_ctrl;
    logic        m_tog, m_irq, m_armed;
    logic [2:0]  ir_sh, car_sh;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_dr = 16'hFFFF; m_cap = 0; m_stage = 0; m_ctrl = 0;
            m_tog = 0; m_irq = 0; m_armed = 0; ir_sh = 0; car_sh = 0;
        end else begin
            bit ir_e, car_e, tk, hit;
            int sel;
            ir_e  = ir_sh[1] && !ir_sh[2];   // R10: two sync flops then edge
            car_e = car_sh[1] && !car_sh[2];
            ir_sh  = {ir_sh[1:0], ir_in};
            car_sh = {car_sh[1:0], carrier_in};
            sel = int'(m_ctrl[2:0]);
            if (m_ctrl[5] && m_ctrl[6]) tk = car_e;          // R9
            else if (sel == 0)          tk = car_e;          // R6
            else                        tk = div_tick[sel-1];
            hit = 0;
            if (!m_ctrl[5]) begin
                if (tk) begin
                    if (m_cnt == m_dr) begin m_cnt = 0; m_tog = !m_tog; hit = 1; end
                    else m_cnt = m_cnt + 1;
                end
            end else if (!m_ctrl[6]) begin
                if (wt_ovf) begin m_cap = m_cnt; m_cnt = 0; m_armed = 1; hit = 1; end
                else begin
                    if (ir_e && m_armed) begin m_cap = m_cnt; m_armed = 0; hit = 1; end
                    if (tk) m_cnt = m_cnt + 1;
                end
            end else begin
                if (wt_ovf) begin m_cap = m_cnt; m_cnt = 0; hit = 1; end
                else if (tk) m_cnt = m_cnt + 1;
            end
            if (hit && m_ctrl[4]) m_irq = 1;
            else if (wr_en && wr_sel == 2'd3) m_irq = 0;
            if (wr_en) begin
                if (wr_sel == 2'd0) m_ctrl = wr_data;
                if (wr_sel == 2'd1) m_stage = wr_data;
                if (wr_sel == 2'd2) m_dr = {m_stage, wr_data};
            end
        end
    end

    task automatic chk(string req, string sig, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s/%s %s act=%h exp=%h t=%0t", phase, req, sig, act, exp, $time);
        end
    endtask

    logic last_pin = 0;
    task automatic step();
        @(negedge clk);
        chk("R1", "pin_out", {15'd0, pin_out}, {15'd0, m_tog});
        chk("R5", "pin_oe", {15'd0, pin_oe}, {15'd0, m_ctrl[3]});
        chk("R8", "cap_val", cap_val, m_cap);
        chk("R3", "irq_flag", {15'd0, irq_flag}, {15'd0, m_irq});
        if (pin_out != last_pin) toggles++;
        last_pin = pin_out;
        wr_en = 0; wt_ovf = 0;
        for (int i = 0; i < 7; i++) div_tick[i] = ($urandom % 100) < tick_pct;
        if (car_rand) carrier_in = $urandom % 2;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; wr_sel = a; wr_data = d;
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R2"; // reset state, data register 0xFFFF
        steps(4);

        phase = "R1"; // compare toggle, tick on div_tick[0], D = 3
        wr(2'd0, 8'h19);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h03);
        tick_pct = 100;
        toggles = 0;
        steps(40);
        phase = "R4"; // D+1 = 4 ticks per toggle with a steady tick
        total++;
        if (toggles < 8 || toggles > 11) begin
            bad++;
            $display("FAIL R4 toggles act=%0d exp=~10", toggles);
        end
        tick_pct = 40;
        steps(60);

        phase = "R7"; // only high byte written: compare value unchanged
        wr(2'd1, 8'h00);
        steps(30);
        wr(2'd2, 8'h07);
        steps(40);

        phase = "R3"; // clears, including clears that meet matches
        for (int k = 0; k < 30; k++) begin
            wr(2'd3, 8'h00);
            steps(k % 5);
        end

        phase = "R6"; // carrier as source, then div_tick[1]
        wr(2'd0, 8'h18);
        car_rand = 1;
        steps(120);
        wr(2'd0, 8'h1A);
        car_rand = 0;
        steps(80);

        phase = "R5"; // pin enable off
        wr(2'd0, 8'h12);
        steps(20);

        phase = "R8"; // envelope capture
        wr(2'd0, 8'h31);
        wt_ovf = 1; step();
        steps(10);
        ir_in = 1; steps(8);
        ir_in = 0; steps(4);
        ir_in = 1; steps(6);   // later edge, ignored (disarmed)
        ir_in = 0; steps(3);
        wt_ovf = 1; step();
        steps(5);
        // coincidence: synchronized IR edge meets overflow
        ir_in = 1; step(); step();
        wt_ovf = 1; step();
        steps(6);
        ir_in = 0; steps(4);
        phase = "R11"; // output holds in capture modes
        steps(10);

        phase = "R10"; // synchronizer latency under random IR edges
        for (int k = 0; k < 40; k++) begin
            ir_in = $urandom % 2;
            if ((k % 9) == 0) wt_ovf = 1;
            step();
        end

        phase = "R9"; // carrier count ignores clk_sel and IR
        wr(2'd0, 8'h75);
        car_rand = 1;
        for (int k = 0; k < 200; k++) begin
            ir_in = $urandom % 2;
            if ((k % 37) == 36) wt_ovf = 1;
            step();
        end

        phase = "R1"; // mixed random traffic
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h05);
        for (int k = 0; k < 3000; k++) begin
            ir_in = $urandom % 2;
            if (($urandom % 23) == 0) wt_ovf = 1;
            if (($urandom % 50) == 0) begin
                wr_en = 1; wr_sel = $urandom % 4;
                wr_data = (wr_sel == 2'd0) ? {1'b0, 7'($urandom)} : 8'($urandom % 8);
            end
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule